// File: doc/BRIEF.md
# CAN Transmit Mailbox Status Tracker

This block holds the state of three transmit mailboxes of a CAN controller. It tracks which mailboxes hold a frame and the order in which software filled them. It also keeps per-mailbox event flags that the protocol engine raises and software clears. All of this is presented as one 32-bit status word, together with the index of the mailbox that is next in line to go onto the bus.

Software fills a mailbox with a load strobe and can ask for a pending frame to be stopped. The protocol engine reports three kinds of outcome for each mailbox: success, transmit error or lost arbitration. A success always frees the mailbox. An error or a lost arbitration frees it only once a stop has been requested; otherwise the frame stays queued for another attempt. Software clears event flags by writing ones to the status word.

All outputs are registered: a strobe seen at one clock edge is visible in the status word right after that edge.

Top module: `txMailboxStatus`

## Requirements
- R1: During and right after reset the status word is 0x1C00_0000 (all three empty flags set) and nextSendValid is 0.
- R2: A load strobe on an empty mailbox m clears its empty flag (bit 26+m) after the next edge and appends m to the tail of the send order. When several mailboxes load in the same cycle, the lower index goes first. A load on a non-empty mailbox is ignored.
- R3: A success strobe on a pending mailbox m sets its empty flag, its finished flag (bit 8m) and its finished-without-error flag (bit 8m+1), and removes m from the send order.
- R4: A stop request on a pending mailbox sets its stop flag (bit 8m+7). A stop request on an empty mailbox is ignored. While the stop flag is set, an error or a lost-arbitration strobe frees the mailbox and removes it from the order. The stop flag clears whenever the mailbox is freed.
- R5: With no stop flag, an error strobe sets the error flag (bit 8m+3) and the finished flag (bit 8m), and a lost-arbitration strobe sets the arbitration flag (bit 8m+2). In both cases the mailbox stays pending and keeps its place in the order.
- R6: The last-in-order flag of mailbox m (bit 29+m) is 1 exactly when m is at the tail of the send order and at least two mailboxes are pending.
- R7: nextSendValid is 1 when any mailbox is pending, and nextSendIdx then gives the oldest pending mailbox. The 2-bit number field (bits 25:24) gives the lowest-index empty mailbox if one exists, and the oldest pending mailbox otherwise.
- R8: A clear write (clrWrEn high) clears each event bit whose clrWrData bit is 1. Zero bits leave flags unchanged. A hardware set in the same cycle wins over the clear. Stop, empty, last and number bits are not changed by the write.
- R9: Success, error and lost-arbitration strobes on an empty mailbox change nothing.
- R10: Bits 22:20, 14:12 and 6:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStb | input | 3 | Per-mailbox load strobe from software |
| doneStb | input | 3 | Per-mailbox successful transmission from the protocol engine |
| errStb | input | 3 | Per-mailbox transmit error from the protocol engine |
| arbLostStb | input | 3 | Per-mailbox arbitration lost from the protocol engine |
| stopReq | input | 3 | Per-mailbox stop request from software |
| clrWrEn | input | 1 | Write-one-to-clear strobe for the status word |
| clrWrData | input | 32 | Clear mask, aligned with the status word |
| statusWord | output | 32 | Packed status word |
| nextSendValid | output | 1 | At least one mailbox is pending |
| nextSendIdx | output | 2 | Oldest pending mailbox |

## Verification
The following invariants are checked on every cycle:
- reserved bits read zero;
- at most one last-in-order flag is set, never on an empty mailbox and never with fewer than two pending;
- nextSendIdx points at a pending mailbox;
- a load, a success, a stop request and a finished-flag clear each take effect at the next edge;
- strobes on an empty mailbox raise no flags.

Only the bench's scenarios can show the other behaviour. That covers the actual order across loads and removals, including same-cycle loads and mid-queue removal. It also covers the number field's choice between a free slot and the queue head, a hardware set winning over a clear in the same cycle, and stop-gated release on error or lost arbitration. The bench compares each of these against its own queue model.

// File: rtl/txMailboxPkg.sv
package txMailboxPkg;
  localparam int NUM_MB    = 3;
  localparam int IDX_W     = 2;
  localparam int WORD_W    = 32;
  localparam int LANE_W    = 8;
  localparam int EV_W      = 4;
  localparam int STOP_POS  = 7;
  localparam int NUM_LSB   = 24;
  localparam int EMPTY_LSB = NUM_LSB + IDX_W;
  localparam int LAST_LSB  = EMPTY_LSB + NUM_MB;
  // event bit positions inside a lane
  localparam int EV_FIN = 0;
  localparam int EV_OK  = 1;
  localparam int EV_ARB = 2;
  localparam int EV_ERR = 3;

  typedef struct packed {
    logic [NUM_MB-1:0] enq;
    logic [NUM_MB-1:0] rel;
    logic [NUM_MB-1:0] setStop;
    logic [NUM_MB-1:0] setFin;
    logic [NUM_MB-1:0] setOk;
    logic [NUM_MB-1:0] setArb;
    logic [NUM_MB-1:0] setErr;
    logic [WORD_W-1:0] clrMask;
  } ctrlStbT;

  function automatic logic [WORD_W-1:0] evMask();
    logic [WORD_W-1:0] w = '0;
    for (int m = 0; m < NUM_MB; m++) w[m*LANE_W +: EV_W] = '1;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] rsvMask();
    logic [WORD_W-1:0] w = '0;
    for (int m = 0; m < NUM_MB; m++) w[m*LANE_W+EV_W +: STOP_POS-EV_W] = '1;
    return w;
  endfunction
endpackage

// File: rtl/txMailboxCtrl.sv
module txMailboxCtrl
  import txMailboxPkg::*;
(
  input  logic [NUM_MB-1:0] loadStb,
  input  logic [NUM_MB-1:0] doneStb,
  input  logic [NUM_MB-1:0] errStb,
  input  logic [NUM_MB-1:0] arbLostStb,
  input  logic [NUM_MB-1:0] stopReq,
  input  logic [NUM_MB-1:0] emptyQ,
  input  logic [NUM_MB-1:0] stopQ,
  input  logic              clrWrEn,
  input  logic [WORD_W-1:0] clrWrData,
  output ctrlStbT           stb
);
  logic [NUM_MB-1:0] pendV;
  assign pendV = ~emptyQ;

  always_comb begin
    stb = '0;
    stb.clrMask = clrWrEn ? clrWrData : '0;
    for (int m = 0; m < NUM_MB; m++) begin
      stb.enq[m]     = loadStb[m] & emptyQ[m];
      stb.setStop[m] = stopReq[m] & pendV[m];
      stb.setOk[m]   = doneStb[m] & pendV[m];
      stb.setErr[m]  = errStb[m] & pendV[m];
      stb.setArb[m]  = arbLostStb[m] & pendV[m];
      stb.setFin[m]  = pendV[m] & (doneStb[m] | errStb[m] | (arbLostStb[m] & stopQ[m]));
      stb.rel[m]     = pendV[m] & (doneStb[m] | (stopQ[m] & (errStb[m] | arbLostStb[m])));
    end
  end
endmodule

// File: rtl/txMailboxDatapath.sv
module txMailboxDatapath
  import txMailboxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStbT           stb,
  output logic [NUM_MB-1:0] emptyQ,
  output logic [NUM_MB-1:0] stopQ,
  output logic [WORD_W-1:0] statusWord,
  output logic              nextSendValid,
  output logic [IDX_W-1:0]  nextSendIdx
);
  localparam logic [WORD_W-1:0] EV_MASK = evMask();

  logic [WORD_W-1:0] evQ, evNext, setW;
  logic [NUM_MB-1:0][NUM_MB-1:0] olderQ, olderNext;  // olderQ[i][j]: i loaded before j
  logic [NUM_MB-1:0] pendV, headV, tailV, lastV;
  logic [IDX_W-1:0]  headIdx, freeIdx, numIdx;

  assign pendV = ~emptyQ;

  always_comb begin
    setW = '0;
    for (int m = 0; m < NUM_MB; m++) begin
      setW[m*LANE_W + EV_FIN] = stb.setFin[m];
      setW[m*LANE_W + EV_OK]  = stb.setOk[m];
      setW[m*LANE_W + EV_ARB] = stb.setArb[m];
      setW[m*LANE_W + EV_ERR] = stb.setErr[m];
    end
    evNext = ((evQ & ~stb.clrMask) | setW) & EV_MASK;
  end

  always_comb begin
    olderNext = olderQ;
    for (int i = 0; i < NUM_MB; i++) begin
      if (stb.enq[i]) begin
        for (int j = 0; j < NUM_MB; j++) begin
          if (j != i) begin
            olderNext[i][j] = stb.enq[j] && (j > i);
            olderNext[j][i] = !stb.enq[j] || (j < i);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emptyQ <= '1;
      stopQ  <= '0;
      evQ    <= '0;
      olderQ <= '0;
    end else begin
      evQ    <= evNext;
      olderQ <= olderNext;
      for (int m = 0; m < NUM_MB; m++) begin
        if (stb.rel[m])      emptyQ[m] <= 1'b1;
        else if (stb.enq[m]) emptyQ[m] <= 1'b0;
        stopQ[m] <= !stb.rel[m] && (stopQ[m] || stb.setStop[m]);
      end
    end
  end

  always_comb begin
    headV = pendV;
    tailV = pendV;
    for (int m = 0; m < NUM_MB; m++) begin
      for (int k = 0; k < NUM_MB; k++) begin
        if (k != m && pendV[k]) begin
          if (olderQ[k][m]) headV[m] = 1'b0;
          if (olderQ[m][k]) tailV[m] = 1'b0;
        end
      end
    end
    lastV = ($countones(pendV) >= 2) ? tailV : '0;
    headIdx = '0;
    freeIdx = '0;
    for (int m = NUM_MB - 1; m >= 0; m--) begin
      if (headV[m])  headIdx = IDX_W'(m);
      if (emptyQ[m]) freeIdx = IDX_W'(m);
    end
    numIdx = (|emptyQ) ? freeIdx : headIdx;
  end

  always_comb begin
    statusWord = evQ;
    for (int m = 0; m < NUM_MB; m++) statusWord[m*LANE_W + STOP_POS] = stopQ[m];
    statusWord[NUM_LSB +: IDX_W]    = numIdx;
    statusWord[EMPTY_LSB +: NUM_MB] = emptyQ;
    statusWord[LAST_LSB +: NUM_MB]  = lastV;
  end

  assign nextSendValid = |pendV;
  assign nextSendIdx   = headIdx;
endmodule

// File: rtl/txMailboxStatus.sv
module txMailboxStatus
  import txMailboxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_MB-1:0] loadStb,
  input  logic [NUM_MB-1:0] doneStb,
  input  logic [NUM_MB-1:0] errStb,
  input  logic [NUM_MB-1:0] arbLostStb,
  input  logic [NUM_MB-1:0] stopReq,
  input  logic              clrWrEn,
  input  logic [WORD_W-1:0] clrWrData,
  output logic [WORD_W-1:0] statusWord,
  output logic              nextSendValid,
  output logic [IDX_W-1:0]  nextSendIdx
);
  ctrlStbT           stb;
  logic [NUM_MB-1:0] emptyQ, stopQ;

  txMailboxCtrl ctrl_i (
    .loadStb(loadStb), .doneStb(doneStb), .errStb(errStb),
    .arbLostStb(arbLostStb), .stopReq(stopReq),
    .emptyQ(emptyQ), .stopQ(stopQ),
    .clrWrEn(clrWrEn), .clrWrData(clrWrData), .stb(stb)
  );

  txMailboxDatapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .emptyQ(emptyQ), .stopQ(stopQ), .statusWord(statusWord),
    .nextSendValid(nextSendValid), .nextSendIdx(nextSendIdx)
  );
endmodule

// File: rtl/txMailboxChecker.sv
module txMailboxChecker
  import txMailboxPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [NUM_MB-1:0] loadStb,
  input logic [NUM_MB-1:0] doneStb,
  input logic [NUM_MB-1:0] errStb,
  input logic [NUM_MB-1:0] arbLostStb,
  input logic [NUM_MB-1:0] stopReq,
  input logic              clrWrEn,
  input logic [NUM_MB-1:0] clrFin,
  input logic [WORD_W-1:0] statusWord,
  input logic              nextSendValid,
  input logic [IDX_W-1:0]  nextSendIdx
);
  localparam logic [WORD_W-1:0] RSV_MASK = rsvMask();
  logic [NUM_MB-1:0] emptyS, lastS;
  assign emptyS = statusWord[EMPTY_LSB +: NUM_MB];
  assign lastS  = statusWord[LAST_LSB +: NUM_MB];

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord & RSV_MASK) == '0);
  // R6
  last_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(lastS) <= 1);
  // R6
  last_needs_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|lastS) |-> ($countones(emptyS) <= NUM_MB - 2));
  // R6
  last_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastS & emptyS) == '0);
  // R7
  next_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    nextSendValid == (emptyS != '1));
  // R7
  next_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    nextSendValid |-> !emptyS[nextSendIdx]);

  for (genvar m = 0; m < NUM_MB; m++) begin : g_mb
    // R2
    load_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
      (loadStb[m] && emptyS[m]) |=> !emptyS[m]);
    // R3
    done_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
      (doneStb[m] && !emptyS[m]) |=> (emptyS[m] && statusWord[m*LANE_W + EV_FIN]));
    // R4
    stop_marks_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stopReq[m] && !emptyS[m]) |=> (statusWord[m*LANE_W + STOP_POS] || emptyS[m]));
    // R8
    w1c_fin_chk: assert property (@(posedge clk) disable iff (!rstN)
      (clrWrEn && clrFin[m] && !doneStb[m] && !errStb[m] && !arbLostStb[m])
      |=> !statusWord[m*LANE_W + EV_FIN]);
    // R9
    event_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
      (emptyS[m] && !statusWord[m*LANE_W + EV_FIN]) |=> !statusWord[m*LANE_W + EV_FIN]);
  end
endmodule

bind txMailboxStatus txMailboxChecker chk_i (
  .clk(clk), .rstN(rstN), .loadStb(loadStb), .doneStb(doneStb),
  .errStb(errStb), .arbLostStb(arbLostStb), .stopReq(stopReq),
  .clrWrEn(clrWrEn), .clrFin({clrWrData[16], clrWrData[8], clrWrData[0]}),
  .statusWord(statusWord), .nextSendValid(nextSendValid), .nextSendIdx(nextSendIdx)
);

// File: tb/txMailboxStatus_tb_top.sv
module txMailboxStatus_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  loadStb = '0, doneStb = '0, errStb = '0, arbLostStb = '0, stopReq = '0;
  logic        clrWrEn = 1'b0;
  logic [31:0] clrWrData = '0;
  logic [31:0] statusWord;
  logic        nextSendValid;
  logic [1:0]  nextSendIdx;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [2:0] mEmpty = 3'b111;
  logic [2:0] mStop = 3'b000;
  logic [3:0] mEv [3] = '{4'h0, 4'h0, 4'h0};
  int         q [3] = '{0, 0, 0};
  int         qLen = 0;

  always #5 clk = ~clk;

  txMailboxStatus dut_i (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .doneStb(doneStb), .errStb(errStb),
    .arbLostStb(arbLostStb), .stopReq(stopReq), .clrWrEn(clrWrEn), .clrWrData(clrWrData),
    .statusWord(statusWord), .nextSendValid(nextSendValid), .nextSendIdx(nextSendIdx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus();
    logic [31:0] w = '0;
    int lowFree = -1;
    for (int m = 0; m < 3; m++) begin
      w[m*8 +: 4] = mEv[m];
      w[m*8 + 7]  = mStop[m];
      w[26 + m]   = mEmpty[m];
    end
    for (int m = 2; m >= 0; m--) if (mEmpty[m]) lowFree = m;
    if (lowFree >= 0) w[25:24] = 2'(lowFree);
    else              w[25:24] = 2'(q[0]);
    if (qLen >= 2) w[29 + q[qLen-1]] = 1'b1;
    return w;
  endfunction

  task automatic modelStep(input logic [2:0] ld, dn, er, ar, sp, input logic we, input logic [31:0] wd);
    logic [2:0] rel;
    int nq [3] = '{0, 0, 0};
    int nl = 0;
    for (int m = 0; m < 3; m++) begin
      logic pend = !mEmpty[m];
      logic [3:0] setV;
      setV = {pend & er[m], pend & ar[m], pend & dn[m],
              pend & (dn[m] | er[m] | (ar[m] & mStop[m]))};
      rel[m] = pend & (dn[m] | (mStop[m] & (er[m] | ar[m])));
      mEv[m] = (mEv[m] & ~(we ? wd[m*8 +: 4] : 4'h0)) | setV;
    end
    for (int k = 0; k < qLen; k++) if (!rel[q[k]]) begin nq[nl] = q[k]; nl++; end
    for (int m = 0; m < 3; m++) if (ld[m] && mEmpty[m]) begin nq[nl] = m; nl++; end
    for (int m = 0; m < 3; m++) begin
      mStop[m] = !rel[m] && (mStop[m] || (sp[m] && !mEmpty[m]));
      if (rel[m]) mEmpty[m] = 1'b1;
      else if (ld[m]) mEmpty[m] = 1'b0;
    end
    q = nq;
    qLen = nl;
  endtask

  task automatic compareAll();
    logic [31:0] e = expStatus();
    check("R2 empty",    statusWord & 32'h1C00_0000, e & 32'h1C00_0000);
    check("R6 last",     statusWord & 32'hE000_0000, e & 32'hE000_0000);
    check("R7 number",   statusWord & 32'h0300_0000, e & 32'h0300_0000);
    check("R4 stop",     statusWord & 32'h0080_8080, e & 32'h0080_8080);
    check("R5 events",   statusWord & 32'h000F_0F0F, e & 32'h000F_0F0F);
    check("R10 reserved", statusWord & 32'h0070_7070, 32'h0);
    check("R7 valid", {31'b0, nextSendValid}, {31'b0, qLen > 0});
    if (qLen > 0) check("R7 head", {30'b0, nextSendIdx}, 32'(q[0]));
  endtask

  task automatic tick(input logic [2:0] ld, dn, er, ar, sp, input logic we, input logic [31:0] wd);
    @(negedge clk);
    loadStb = ld; doneStb = dn; errStb = er; arbLostStb = ar; stopReq = sp;
    clrWrEn = we; clrWrData = wd;
    modelStep(ld, dn, er, ar, sp, we, wd);
    @(posedge clk);
    #1;
    compareAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seedV;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset word", statusWord, 32'h1C00_0000);
    check("R1 reset valid", {31'b0, nextSendValid}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", statusWord, 32'h1C00_0000);

    // R2: simultaneous loads, lower index first; R6 tail is mailbox 2
    tick(3'b111, 0, 0, 0, 0, 0, 0);
    check("R2 R6 all loaded", statusWord, 32'h8000_0000);
    check("R7 head 0", {30'b0, nextSendIdx}, 32'd0);
    // R3: success on mailbox 0
    tick(0, 3'b001, 0, 0, 0, 0, 0);
    check("R3 done mb0", statusWord, 32'h8400_0003);
    check("R7 head 1", {30'b0, nextSendIdx}, 32'd1);
    // R2 reload mb0 to tail; R7 number shows head when full
    tick(3'b001, 0, 0, 0, 0, 0, 0);
    check("R2 R7 reload mb0", statusWord, 32'h2100_0003);
    // R5 error without stop keeps mb2 pending
    tick(0, 0, 3'b100, 0, 0, 0, 0);
    check("R5 err mb2", statusWord, 32'h2109_0003);
    // R4 stop request then lost arbitration frees mb2
    tick(0, 0, 0, 0, 3'b100, 0, 0);
    check("R4 stop mb2", statusWord, 32'h2189_0003);
    tick(0, 0, 0, 3'b100, 0, 0, 0);
    check("R4 release mb2", statusWord, 32'h320D_0003);
    // R8 clear write with same-cycle hardware set on mb1
    tick(0, 0, 3'b010, 0, 0, 1'b1, 32'h108F_0981);
    check("R8 w1c", statusWord, 32'h3200_0902);
    // R9 strobes on empty mailbox 2
    tick(0, 3'b100, 3'b100, 3'b100, 3'b100, 0, 0);
    check("R9 empty ignored", statusWord, 32'h3200_0902);
    // R2 load on pending mailbox 1 ignored
    tick(3'b010, 0, 0, 0, 0, 0, 0);
    check("R2 load busy ignored", statusWord, 32'h3200_0902);
    // R8 zero write no effect
    tick(0, 0, 0, 0, 0, 1'b1, 32'h0);
    check("R8 zero write", statusWord, 32'h3200_0902);

    seedV = $urandom(32'h00C0_FFEE);
    for (int n = 0; n < 400; n++) begin
      tick(3'($urandom) & 3'($urandom),
           3'($urandom) & 3'($urandom) & 3'($urandom),
           3'($urandom) & 3'($urandom) & 3'($urandom),
           3'($urandom) & 3'($urandom) & 3'($urandom),
           3'($urandom) & 3'($urandom),
           ($urandom % 4) == 0, $urandom);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule